// File: doc/BRIEF.md
# Multiplexed Seven-Segment Display Driver

This block lights four seven-segment digits of the common-cathode kind. All four share a single 8-bit segment bus, and each digit has its own active-low select line. The driver takes one 4-bit value and one decimal-point bit for each digit and turns each value into its hexadecimal glyph. It then enables the digits one at a time. The switching is fast enough that the eye sees all four digits lit together.

Each digit stays enabled for a dwell of one millisecond. The dwell length is set by a parameter that gives the number of clock cycles in a millisecond. At the default of 100,000 cycles on a 100 MHz clock, a full pass over the four digits takes 4 ms, which is a refresh rate of 250 Hz. Select line 0 drives the leftmost digit, and the scan moves from left to right.

Top module: `seg_scan_driver`

## Requirements
- R1: While reset is asserted, every select line is high (`dig_sel_n` = 4'hF) and the segment bus is 8'h00.
- R2: On the first clock edge after reset is released, select line 0 goes low. From then on, exactly one select line is low in every cycle.
- R3: While select line s is low, the segment bus shows digit number 3-s. Digit k is taken from `digit_val[4k+3:4k]` and `dp_mask[k]`. So select line 0 shows digit 3, the leftmost digit.
- R4: Each select line stays low for exactly CYC_PER_MS cycles. The scan then moves from line s to line s+1, and after line 3 it returns to line 0.
- R5: Segment bits 0 to 6 drive segments a to g, and a 1 lights the segment. The glyphs for values 0 to F are 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F, 6F, 77, 7C, 39, 5E, 79, 71.
- R6: Segment bit 7 is the decimal point. It equals the `dp_mask` bit of the digit being shown.
- R7: The select bus and the segment bus are both registered and change on the same clock edge. A change on an input appears on the segment bus one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| digit_val | input | 16 | Four 4-bit digit values; digit k is in bits 4k+3:4k |
| dp_mask | input | 4 | Decimal-point enable; bit k belongs to digit k |
| seg_o | output | 8 | Segment bus: bits 0-6 are segments a-g, bit 7 is the decimal point; active high |
| dig_sel_n | output | 4 | Active-low digit selects; line 0 is the leftmost digit |

## Verification
The digit values change on every clock cycle, each digit following its own offset sequence. As a result, every select line shows all sixteen glyphs over the run, together with both states of its decimal point. Giving neighbouring digits different values in the same cycle makes a wrong digit-to-line mapping show up as a wrong glyph. Changing the inputs every cycle also exposes a segment bus that lags the select bus, or that holds a stale value for the whole dwell. A reset in the middle of the scan must blank the display and restart the scan at line 0, which separates a true restart from a scan that only wraps around.

// File: rtl/segscan_pkg.sv
package segscan_pkg;

    localparam int NIB_W = 4;
    localparam int SEG_W = 8;

endpackage

// File: rtl/glyph_decoder.sv
module glyph_decoder
    import segscan_pkg::*;
(
    input  logic [NIB_W-1:0] nib,
    output logic [6:0]       glyph
);
    // bit 0 = segment a ... bit 6 = segment g, 1 = lit
    always_comb begin
        unique case (nib)
            4'h0: glyph = 7'h3F;
            4'h1: glyph = 7'h06;
            4'h2: glyph = 7'h5B;
            4'h3: glyph = 7'h4F;
            4'h4: glyph = 7'h66;
            4'h5: glyph = 7'h6D;
            4'h6: glyph = 7'h7D;
            4'h7: glyph = 7'h07;
            4'h8: glyph = 7'h7F;
            4'h9: glyph = 7'h6F;
            4'hA: glyph = 7'h77;
            4'hB: glyph = 7'h7C;
            4'hC: glyph = 7'h39;
            4'hD: glyph = 7'h5E;
            4'hE: glyph = 7'h79;
            default: glyph = 7'h71;
        endcase
    end
endmodule

// File: rtl/dwell_timer.sv
module dwell_timer #(
    parameter int CYC_PER_MS = 100000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (CYC_PER_MS > 1) ? $clog2(CYC_PER_MS) : 1;
    localparam logic [CW-1:0] LAST = CW'(CYC_PER_MS - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    assign tick = run && (tmr_q.cnt == LAST);

    always_comb begin
        tmr_d = tmr_q;
        if (!run || tick) begin
            tmr_d.cnt = '0;
        end else begin
            tmr_d.cnt = tmr_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_q.cnt <= LAST); // R4
    AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> tmr_q.cnt == '0); // R4
endmodule

// File: rtl/seg_scan_driver.sv
module seg_scan_driver
    import segscan_pkg::*;
#(
    parameter int DIGITS     = 4,
    parameter int CYC_PER_MS = 100000
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [DIGITS*NIB_W-1:0]   digit_val,
    input  logic [DIGITS-1:0]         dp_mask,
    output logic [SEG_W-1:0]          seg_o,
    output logic [DIGITS-1:0]         dig_sel_n
);
    localparam int IDX_W = (DIGITS > 1) ? $clog2(DIGITS) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DIGITS - 1);

    typedef struct packed {
        logic              active;
        logic [IDX_W-1:0]  idx;
        logic [SEG_W-1:0]  seg;
        logic [DIGITS-1:0] sel_n;
    } scan_t;

    scan_t scan_d, scan_q;
    logic  tick;
    logic [6:0] glyph [DIGITS];

    generate
        for (genvar g = 0; g < DIGITS; g++) begin : g_dec
            glyph_decoder u_dec (
                .nib   (digit_val[g*NIB_W +: NIB_W]),
                .glyph (glyph[g])
            );
        end
    endgenerate

    dwell_timer #(.CYC_PER_MS(CYC_PER_MS)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (scan_q.active),
        .tick  (tick)
    );

    always_comb begin
        logic [IDX_W-1:0] nxt_idx;
        logic [IDX_W-1:0] dnum;
        scan_d = scan_q;
        if (!scan_q.active) begin
            nxt_idx = '0;
        end else if (tick) begin
            nxt_idx = (scan_q.idx == LAST_IDX) ? '0 : scan_q.idx + 1'b1;
        end else begin
            nxt_idx = scan_q.idx;
        end
        dnum          = LAST_IDX - nxt_idx;
        scan_d.active = 1'b1;
        scan_d.idx    = nxt_idx;
        scan_d.seg    = {dp_mask[dnum], glyph[dnum]};
        for (int i = 0; i < DIGITS; i++) begin
            scan_d.sel_n[i] = (nxt_idx != IDX_W'(i));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scan_q.active <= 1'b0;
            scan_q.idx    <= '0;
            scan_q.seg    <= '0;
            scan_q.sel_n  <= '1;
        end else begin
            scan_q <= scan_d;
        end
    end

    assign seg_o     = scan_q.seg;
    assign dig_sel_n = scan_q.sel_n;

    AST_DARK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !scan_q.active |-> (dig_sel_n == '1) && (seg_o == '0)); // R1
    AST_FIRST_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scan_q.active) |-> !dig_sel_n[0]); // R2
    AST_ONE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        scan_q.active |-> $countones(dig_sel_n) == DIGITS - 1); // R2
    AST_HOLD_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        scan_q.active && !tick |=> $stable(dig_sel_n)); // R4
    AST_STEP_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        scan_q.active && tick |=> dig_sel_n != $past(dig_sel_n)); // R4
endmodule

// File: tb/sim_seg_scan_driver.sv
module sim_seg_scan_driver;
    localparam int CYC = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] digit_val = '0;
    logic [3:0]  dp_mask = '0;
    logic [7:0]  seg_o;
    logic [3:0]  dig_sel_n;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    seg_scan_driver #(.DIGITS(4), .CYC_PER_MS(CYC)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .digit_val (digit_val),
        .dp_mask   (dp_mask),
        .seg_o     (seg_o),
        .dig_sel_n (dig_sel_n)
    );

    function automatic logic [6:0] ref_glyph(input logic [3:0] v);
        case (v)
            4'h0: return 7'h3F; 4'h1: return 7'h06; 4'h2: return 7'h5B; 4'h3: return 7'h4F;
            4'h4: return 7'h66; 4'h5: return 7'h6D; 4'h6: return 7'h7D; 4'h7: return 7'h07;
            4'h8: return 7'h7F; 4'h9: return 7'h6F; 4'hA: return 7'h77; 4'hB: return 7'h7C;
            4'hC: return 7'h39; 4'hD: return 7'h5E; 4'hE: return 7'h79; default: return 7'h71;
        endcase
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic drive_step(input int s);
        for (int k = 0; k < 4; k++) begin
            digit_val[k*4 +: 4] = 4'((s + k * 7) % 16);
        end
        dp_mask = 4'(s) ^ 4'(s >> 4);
    endtask

    task automatic scan_run(input int ncyc, input int base);
        for (int c = 0; c < ncyc; c++) begin
            @(negedge clk);
            begin
                int li;
                int dn;
                logic [7:0] exp_seg;
                li = (c / CYC) % 4;
                dn = 3 - li;
                exp_seg = {dp_mask[dn], ref_glyph(digit_val[dn*4 +: 4])};
                if (c == 0) check("R2 first line", {4'h0, dig_sel_n}, 8'h0E);
                check("R4 select rotation", {4'h0, dig_sel_n}, {4'h0, ~(4'b1 << li)});
                check("R2 one low", 8'($countones(~dig_sel_n)), 8'd1);
                if (c % CYC == 0)
                    check("R7 seg with select", seg_o, exp_seg);
                else
                    check("R3 R5 R6 glyph", seg_o, exp_seg);
            end
            drive_step(base + c + 1);
        end
    endtask

    initial begin
        drive_step(0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset selects", {4'h0, dig_sel_n}, 8'h0F);
        check("R1 reset segments", seg_o, 8'h00);
        rst_n = 1'b1;
        scan_run(400, 0);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R1 mid reset selects", {4'h0, dig_sel_n}, 8'h0F);
        check("R1 mid reset segments", seg_o, 8'h00);
        drive_step(1000);
        rst_n = 1'b1;
        scan_run(60, 1000);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule